// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects a configurable number of level-sensitive interrupt sources and hands each one to up to four processors. A global register window controls each source's global enable and its CPU target set. Each processor reaches its own view through a per-CPU window, which holds that processor's private mask bits and an acknowledge register. The acknowledge register names the pending source to service. Every processor has one interrupt request line. It stays high while at least one source is deliverable to that processor.

Enable and mask bits are never written as bitfields. Software writes a source number to a "set" or "clear" address, so concurrent agents never need a read-modify-write. One source number is reserved as a per-processor interrupt. It ignores the global enable and the routing register, and only the mask of each processor gates it. Sources 0 and 1 are meant for doorbell summaries. They are treated as ordinary level inputs.

Top module: `irq_distributor`

## Requirements
- R1: A global read at offset 0x000 returns the number of implemented sources in bits [11:2], with every other bit zero.
- R2: A global write of a source number to 0x030 sets that source's global enable. A write to 0x034 clears it.
- R3: A per-CPU write of a source number to 0x048 masks that source for the selected CPU only. A write to 0x04C unmasks it.
- R4: Source n has a routing register at global offset 0x100 + 4·n. Its low NUM_CPU bits are the set of target CPUs (bit c = CPU c), and it reads back as written.
- R5: A per-CPU read at 0x044 returns, in bits [9:0], the lowest-numbered source deliverable to that CPU. Read data appears on the cycle after the read strobe.
- R6: When no source is deliverable to the reading CPU, the acknowledge value is 0x3FF.
- R7: The per-CPU source (number PERCPU_ID, default 5) is deliverable to CPU c exactly when its level is high and CPU c has it unmasked. Global enable and routing have no effect on it.
- R8: After reset, every source is globally disabled and masked on every CPU, and every routing register reads zero.
- R9: irq_o[c] is high exactly when some source is deliverable to CPU c. A normal source is deliverable when its level is high, it is enabled, it is routed to c and it is unmasked on c.
- R10: Reading the acknowledge register changes no state, so repeated reads return the same ID.
- R11: Set/clear writes whose source number in bits [9:0] is not below NUM_SRC have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl_i | input | NUM_SRC | Level-sensitive source inputs |
| g_wr_i | input | 1 | Global window write strobe |
| g_rd_i | input | 1 | Global window read strobe |
| g_addr_i | input | ADDR_W | Global window byte offset |
| g_wdata_i | input | 32 | Global write data |
| g_rdata_o | output | 32 | Global read data, valid the cycle after g_rd_i |
| c_wr_i | input | 1 | Per-CPU window write strobe |
| c_rd_i | input | 1 | Per-CPU window read strobe |
| c_cpu_i | input | CPU_W | Processor issuing the per-CPU access |
| c_addr_i | input | ADDR_W | Per-CPU window byte offset |
| c_wdata_i | input | 32 | Per-CPU write data |
| c_rdata_o | output | 32 | Per-CPU read data, valid the cycle after c_rd_i |
| irq_o | output | NUM_CPU | Interrupt request line per processor |

## Verification
The hardest situation to reach is one where several sources are live at once and each processor sees a different winner. The winners depend on mixed routing sets, per-CPU masks and the per-processor source, which must win while globally disabled and unrouted. The bench first builds a fixed configuration through the set/clear and routing addresses. A vector table then drives different level patterns and checks every request line and one processor's acknowledge ID for each pattern. Directed steps follow: disabling, masking, out-of-range numbers and re-masking the per-processor source, each confirmed through later acknowledge reads.

// File: rtl/dist_pkg.sv
package dist_pkg;
    localparam int ID_W          = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'h3FF;
    localparam int OFF_CTRL      = 'h000;
    localparam int OFF_EN_SET    = 'h030;
    localparam int OFF_EN_CLR    = 'h034;
    localparam int OFF_ACK       = 'h044;
    localparam int OFF_MSK_SET   = 'h048;
    localparam int OFF_MSK_CLR   = 'h04C;
    localparam int OFF_ROUTE     = 'h100;
endpackage

// File: rtl/dist_deliver.sv
module dist_deliver #(
    parameter int NUM_CPU   = 4,
    parameter int NUM_SRC   = 32,
    parameter int PERCPU_ID = 5
) (
    input  logic [NUM_SRC-1:0]              lvl_i,
    input  logic [NUM_SRC-1:0]              en_i,
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0] msk_i,
    input  logic [NUM_SRC-1:0][NUM_CPU-1:0] rte_i,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0] dlv_o
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            if (s == PERCPU_ID) begin : g_local
                assign dlv_o[c][s] = lvl_i[s] & ~msk_i[c][s];
            end else begin : g_shared
                assign dlv_o[c][s] = lvl_i[s] & en_i[s] & rte_i[s][c] & ~msk_i[c][s];
            end
        end
    end
endmodule

// File: rtl/dist_pick.sv
module dist_pick #(
    parameter int W    = 32,
    parameter int ID_W = 10
) (
    input  logic [W-1:0]    req_i,
    output logic            hit_o,
    output logic [ID_W-1:0] id_o
);
    always_comb begin
        id_o = '1;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) id_o = ID_W'(i);
        end
        hit_o = |req_i;
    end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import dist_pkg::*;
#(
    parameter int NUM_CPU   = 4,
    parameter int NUM_SRC   = 32,
    parameter int PERCPU_ID = 5,
    parameter int ADDR_W    = 12,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl_i,
    input  logic               g_wr_i,
    input  logic               g_rd_i,
    input  logic [ADDR_W-1:0]  g_addr_i,
    input  logic [31:0]        g_wdata_i,
    output logic [31:0]        g_rdata_o,
    input  logic               c_wr_i,
    input  logic               c_rd_i,
    input  logic [CPU_W-1:0]   c_cpu_i,
    input  logic [ADDR_W-1:0]  c_addr_i,
    input  logic [31:0]        c_wdata_i,
    output logic [31:0]        c_rdata_o,
    output logic [NUM_CPU-1:0] irq_o
);
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0]              en;
        logic [NUM_CPU-1:0][NUM_SRC-1:0] msk;
        logic [NUM_SRC-1:0][NUM_CPU-1:0] rte;
        logic [31:0]                     grd;
        logic [31:0]                     crd;
    } dist_st_t;

    dist_st_t st_d, st_q;

    logic [NUM_CPU-1:0][NUM_SRC-1:0] dlv;
    logic [NUM_CPU-1:0][ID_W-1:0]    pick_id;
    logic [NUM_CPU-1:0]              pick_hit;

    dist_deliver #(
        .NUM_CPU  (NUM_CPU),
        .NUM_SRC  (NUM_SRC),
        .PERCPU_ID(PERCPU_ID)
    ) u_deliver (
        .lvl_i(src_lvl_i),
        .en_i (st_q.en),
        .msk_i(st_q.msk),
        .rte_i(st_q.rte),
        .dlv_o(dlv)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_pick
        dist_pick #(
            .W   (NUM_SRC),
            .ID_W(ID_W)
        ) u_pick (
            .req_i(dlv[c]),
            .hit_o(pick_hit[c]),
            .id_o (pick_id[c])
        );
    end

    assign irq_o     = pick_hit;
    assign g_rdata_o = st_q.grd;
    assign c_rdata_o = st_q.crd;

    // Write-side decode
    logic [ID_W-1:0]   g_idx, c_idx;
    logic              g_idx_ok, c_idx_ok, cpu_ok;
    logic [ADDR_W-1:0] r_off;
    logic              r_hit;
    logic [SRC_W-1:0]  r_idx;
    logic [CPU_W-1:0]  cpu_sel;

    always_comb begin
        g_idx    = g_wdata_i[ID_W-1:0];
        c_idx    = c_wdata_i[ID_W-1:0];
        g_idx_ok = 32'(g_idx) < NUM_SRC;
        c_idx_ok = 32'(c_idx) < NUM_SRC;
        cpu_ok   = 32'(c_cpu_i) < NUM_CPU;
        cpu_sel  = c_cpu_i;
        r_off    = g_addr_i - ADDR_W'(OFF_ROUTE);
        r_hit    = (32'(g_addr_i) >= OFF_ROUTE) && (r_off[1:0] == 2'b00)
                   && (32'(r_off >> 2) < NUM_SRC);
        r_idx    = SRC_W'(r_off >> 2);
    end

    always_comb begin
        st_d = st_q;

        if (g_wr_i) begin
            if (32'(g_addr_i) == OFF_EN_SET && g_idx_ok)
                st_d.en[g_idx[SRC_W-1:0]] = 1'b1;
            else if (32'(g_addr_i) == OFF_EN_CLR && g_idx_ok)
                st_d.en[g_idx[SRC_W-1:0]] = 1'b0;
            else if (r_hit)
                st_d.rte[r_idx] = g_wdata_i[NUM_CPU-1:0];
        end

        if (c_wr_i && cpu_ok && c_idx_ok) begin
            if (32'(c_addr_i) == OFF_MSK_SET)
                st_d.msk[cpu_sel][c_idx[SRC_W-1:0]] = 1'b1;
            else if (32'(c_addr_i) == OFF_MSK_CLR)
                st_d.msk[cpu_sel][c_idx[SRC_W-1:0]] = 1'b0;
        end

        if (g_rd_i) begin
            st_d.grd = '0;
            if (32'(g_addr_i) == OFF_CTRL)
                st_d.grd = 32'(NUM_SRC) << 2;
            else if (r_hit)
                st_d.grd = 32'(st_q.rte[r_idx]);
        end

        if (c_rd_i) begin
            st_d.crd = '0;
            if (32'(c_addr_i) == OFF_ACK)
                st_d.crd = (cpu_ok && pick_hit[cpu_sel]) ? 32'(pick_id[cpu_sel])
                                                          : 32'(SPURIOUS_ID);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en  <= '0;
            st_q.msk <= '1;
            st_q.rte <= '0;
            st_q.grd <= '0;
            st_q.crd <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dist_chk.sv
module dist_chk
    import dist_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 12,
    parameter int CPU_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               g_rd_i,
    input logic [ADDR_W-1:0]  g_addr_i,
    input logic [31:0]        g_rdata_o,
    input logic               c_rd_i,
    input logic [CPU_W-1:0]   c_cpu_i,
    input logic [ADDR_W-1:0]  c_addr_i,
    input logic [31:0]        c_rdata_o,
    input logic [NUM_CPU-1:0] irq_o
);
    // R1
    ctrl_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g_rd_i && 32'(g_addr_i) == OFF_CTRL) |=> g_rdata_o == (32'(NUM_SRC) << 2));

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_o == '0);

    // R6
    spurious_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd_i && 32'(c_addr_i) == OFF_ACK && !irq_o[c_cpu_i]) |=> c_rdata_o == 32'(SPURIOUS_ID));

    // R9
    real_id_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd_i && 32'(c_addr_i) == OFF_ACK && irq_o[c_cpu_i]) |=> c_rdata_o < 32'(NUM_SRC));

    // R5
    ack_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd_i && 32'(c_addr_i) == OFF_ACK) |=> c_rdata_o[31:ID_W] == '0);
endmodule

bind irq_distributor dist_chk #(
    .NUM_CPU(NUM_CPU),
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W),
    .CPU_W  (CPU_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .g_rd_i   (g_rd_i),
    .g_addr_i (g_addr_i),
    .g_rdata_o(g_rdata_o),
    .c_rd_i   (c_rd_i),
    .c_cpu_i  (c_cpu_i),
    .c_addr_i (c_addr_i),
    .c_rdata_o(c_rdata_o),
    .irq_o    (irq_o)
);

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;
    localparam int NC = 4;
    localparam int NS = 32;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] lvl = '0;
    logic          g_wr = 0, g_rd = 0, c_wr = 0, c_rd = 0;
    logic [AW-1:0] g_addr = '0, c_addr = '0;
    logic [31:0]   g_wdata = '0, c_wdata = '0;
    logic [1:0]    c_cpu = '0;
    logic [31:0]   g_rdata, c_rdata;
    logic [NC-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_distributor u_dut (
        .clk(clk), .rst_n(rst_n), .src_lvl_i(lvl),
        .g_wr_i(g_wr), .g_rd_i(g_rd), .g_addr_i(g_addr), .g_wdata_i(g_wdata), .g_rdata_o(g_rdata),
        .c_wr_i(c_wr), .c_rd_i(c_rd), .c_cpu_i(c_cpu), .c_addr_i(c_addr), .c_wdata_i(c_wdata),
        .c_rdata_o(c_rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic gwr(input int a, input int d);
        @(negedge clk); g_wr = 1; g_addr = AW'(a); g_wdata = 32'(d);
        @(negedge clk); g_wr = 0;
    endtask

    task automatic cwr(input int cpu, input int a, input int d);
        @(negedge clk); c_wr = 1; c_cpu = 2'(cpu); c_addr = AW'(a); c_wdata = 32'(d);
        @(negedge clk); c_wr = 0;
    endtask

    task automatic grd(input int a, output logic [31:0] v);
        @(negedge clk); g_rd = 1; g_addr = AW'(a);
        @(negedge clk); g_rd = 0; v = g_rdata;
    endtask

    task automatic ack(input int cpu, output logic [31:0] v);
        @(negedge clk); c_rd = 1; c_cpu = 2'(cpu); c_addr = 12'h044;
        @(negedge clk); c_rd = 0; v = c_rdata;
    endtask

    task automatic set_lvl(input logic [NS-1:0] v);
        @(negedge clk); lvl = v; #1;
    endtask

    // levels, cpu, expected ack, expected irq
    localparam logic [47:0] VEC [9] = '{
        {32'hFFFF_FFFF, 2'd0, 10'd3,     4'b1111},
        {32'h8000_0200, 2'd0, 10'd9,     4'b0001},
        {32'h8000_0000, 2'd0, 10'd31,    4'b0001},
        {32'h0010_0008, 2'd3, 10'd3,     4'b1001},
        {32'h0010_0000, 2'd3, 10'd20,    4'b1000},
        {32'h0000_00A0, 2'd1, 10'd7,     4'b0110},
        {32'h0000_0020, 2'd2, 10'd5,     4'b0100},
        {32'h0000_0000, 2'd0, 10'h3FF,   4'b0000},
        {32'h0000_0200, 2'd3, 10'h3FF,   4'b0001}
    };

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        set_lvl('1);
        check("R8 irq after reset", 32'(irq), 0);
        ack(0, v);  check("R8 ack after reset", v, 32'h3FF);
        grd(12'h10C, v); check("R8 route after reset", v, 0);
        grd(12'h000, v); check("R1 control count", v, 32'(NS) << 2);

        // source 7 to cpu1
        gwr(12'h030, 7); gwr(12'h11C, 2); cwr(1, 12'h04C, 7);
        #1 check("R9 irq cpu1 only", 32'(irq), 32'b0010);
        ack(1, v); check("R5 cpu1 ack", v, 7);
        ack(0, v); check("R3 cpu0 not unmasked", v, 32'h3FF);
        grd(12'h11C, v); check("R4 route readback", v, 2);

        // per-processor source on cpu2, disabled and unrouted
        cwr(2, 12'h04C, 5);
        ack(2, v); check("R7 local source delivered", v, 5);

        // shared configuration
        gwr(12'h030, 3); gwr(12'h030, 9); gwr(12'h030, 20); gwr(12'h030, 31);
        gwr(12'h10C, 4'b1001); gwr(12'h124, 1); gwr(12'h150, 8); gwr(12'h17C, 1);
        cwr(0, 12'h04C, 3); cwr(0, 12'h04C, 9); cwr(0, 12'h04C, 31);
        cwr(3, 12'h04C, 20); cwr(3, 12'h04C, 3);

        for (int i = 0; i < 9; i++) begin
            set_lvl(VEC[i][47:16]);
            check($sformatf("R9 vec%0d irq", i), 32'(irq), 32'(VEC[i][3:0]));
            ack(int'(VEC[i][15:14]), v);
            check($sformatf("R5/R6 vec%0d ack", i), v, 32'(VEC[i][13:4]));
        end

        set_lvl('1);
        ack(0, v); check("R10 first read", v, 3);
        ack(0, v); check("R10 repeat read", v, 3);

        gwr(12'h034, 3);
        ack(0, v); check("R2 cleared enable", v, 9);
        ack(3, v); check("R2 cleared enable cpu3", v, 20);

        cwr(0, 12'h048, 9);
        ack(0, v); check("R3 masked on cpu0", v, 31);
        ack(3, v); check("R3 other cpu untouched", v, 20);

        gwr(12'h030, 35); cwr(0, 12'h04C, 35); cwr(0, 12'h048, 63);
        ack(0, v); check("R11 out of range ignored", v, 31);

        cwr(2, 12'h048, 5); gwr(12'h030, 5); gwr(12'h114, 4);
        #1 check("R7 masked local source irq", 32'(irq[2]), 0);
        ack(2, v); check("R7 masked local source ack", v, 32'h3FF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule